// File: doc/BRIEF.md
# Serial Canonical Signed Digit Recoder

This block rewrites an unsigned binary constant as a canonical signed digit (CSD) string. That form is also called the non-adjacent form. Each output digit is -1, 0 or +1 and carries the weight 2^i of its position. The constant enters one bit per clock, least significant bit first, on a valid/ready stream. The recoded digits leave the same way on a second valid/ready stream, also least significant first.

The recoder keeps a one-bit carry. It holds each input bit until the bit above it arrives, so every digit depends on the current bit, the next bit and the carry. After the most significant bit it emits one more digit to absorb the leftover carry. A word of n bits therefore yields n+1 digits. A counter reports how many digits of the current word were nonzero.

Usage follows a fixed sequence. Software-free control pulses `start` while the block is not busy, streams the bits with `in_last` on the most significant one, and drains the digits. `nz_count` is final once `busy` falls.

The digit output honours back-pressure. While `out_valid` is high and `out_ready` is low, the digit and its last flag hold unchanged. The block accepts no further input bit until its single output slot can take the next digit. The input side may stall freely, because a digit is produced only when a bit is accepted or during the two closing steps. Words are at most `MAX_BITS` bits long.

Top module: `serial_csd_recoder`

## Requirements
- R1: Each digit is coded {out_nz, out_neg}: 00 is 0, 10 is +1, 11 is -1, and 01 never appears. Digit i of a word carries weight 2^i, and the weighted sum of all digits of a word equals the input value.
- R2: Within one word, no two consecutive digits are both nonzero.
- R3: The value 23 sent as six bits (LSB first: 1,1,1,0,1,0) yields, LSB first, the digits -1, 0, 0, -1, 0, +1 and then a closing 0.
- R4: A word of n input bits yields exactly n+1 digits. Only the final digit has out_last set, and the final digit is never -1.
- R5: After a word, nz_count equals the number of nonzero digits, which is the minimum possible for that value. It is at most (n+2)/2, rounded down, for n input bits.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_nz, out_neg and out_last stay unchanged on the next clock.
- R7: While not busy, in_ready is low and out_valid is low, and input bits offered there are ignored. A start pulse while busy is ignored: the current word finishes correctly and nz_count is not cleared.
- R8: After reset, busy, in_ready and out_valid are low and nz_count is 0.
- R9: An accepted start raises busy on the next clock. busy stays high until the final digit has been taken, and nz_count is cleared by the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new word when not busy |
| busy | output | 1 | High from an accepted start until the final digit is taken |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Recoder can accept the offered bit |
| in_bit | input | 1 | Current constant bit, LSB first |
| in_last | input | 1 | Marks the most significant bit of the word |
| out_valid | output | 1 | A digit is presented |
| out_ready | input | 1 | Consumer takes the presented digit |
| out_nz | output | 1 | Digit is nonzero |
| out_neg | output | 1 | Nonzero digit is -1 |
| out_last | output | 1 | Closing digit of the word |
| nz_count | output | $clog2(MAX_BITS+2) | Nonzero digits of the current word |

## Verification
The recoder is tried with several kinds of constant. The value 23 checks exact digit placement against the known result. An all-ones word makes the carry ripple into the closing digit. An alternating word is already non-adjacent and must pass through unchanged. All-zero and one-bit words test the shortest and emptiest cases. A run of pseudo-random widths and values checks the value rebuilt from the digits, adjacency and the minimum nonzero count against an independent closed-form reference. These runs are repeated with gaps between input bits, with alternate-cycle output stalls and with long output stalls, which separates correct back-pressure from digit loss or duplication. Separate scenarios offer bits while idle and pulse start mid-word, to show that both have no effect.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef struct packed {
    logic nz;
    logic neg;
  } csd_digit_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_RUN,
    ST_TAIL,
    ST_CARRY
  } ctrl_state_e;

endpackage

// File: rtl/csd_step.sv
module csd_step
  import csd_pkg::*;
(
  input  logic       cur,
  input  logic       nxt,
  input  logic       cin,
  output csd_digit_t digit,
  output logic       cout
);

  logic odd_sum;

  assign odd_sum = cur ^ cin;

  always_comb begin
    if (odd_sum) begin
      // odd: pick -1 with carry when the next bit starts a run
      digit.nz  = 1'b1;
      digit.neg = nxt;
      cout      = nxt;
    end else begin
      digit.nz  = 1'b0;
      digit.neg = 1'b0;
      cout      = cur & cin;
    end
  end

endmodule

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl
  import csd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_acc,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_last,
  input  logic       slot_free,
  output logic       in_ready,
  output logic       emit,
  output csd_digit_t emit_digit,
  output logic       emit_last,
  output logic       active
);

  ctrl_state_e st_q, st_d;
  logic        held_q, held_d;
  logic        carry_q, carry_d;
  logic        look_bit;
  csd_digit_t  step_digit;
  logic        step_cout;

  // above the MSB the lookahead bit is zero
  assign look_bit = (st_q == ST_RUN) ? in_bit : 1'b0;

  csd_step u_step (
    .cur   (held_q),
    .nxt   (look_bit),
    .cin   (carry_q),
    .digit (step_digit),
    .cout  (step_cout)
  );

  always_comb begin
    st_d       = st_q;
    held_d     = held_q;
    carry_d    = carry_q;
    in_ready   = 1'b0;
    emit       = 1'b0;
    emit_digit = step_digit;
    emit_last  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_acc) begin
          st_d    = ST_FIRST;
          carry_d = 1'b0;
        end
      end
      ST_FIRST: begin
        in_ready = 1'b1;
        if (in_valid) begin
          held_d = in_bit;
          st_d   = in_last ? ST_TAIL : ST_RUN;
        end
      end
      ST_RUN: begin
        in_ready = slot_free;
        if (in_valid && slot_free) begin
          emit    = 1'b1;
          carry_d = step_cout;
          held_d  = in_bit;
          if (in_last) st_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (slot_free) begin
          emit    = 1'b1;
          carry_d = step_cout;
          st_d    = ST_CARRY;
        end
      end
      ST_CARRY: begin
        emit_digit.nz  = carry_q;
        emit_digit.neg = 1'b0;
        emit_last      = 1'b1;
        if (slot_free) begin
          emit    = 1'b1;
          carry_d = 1'b0;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      held_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      held_q  <= held_d;
      carry_q <= carry_d;
    end
  end

  assign active = (st_q != ST_IDLE);

endmodule

// File: rtl/csd_out_slot.sv
module csd_out_slot
  import csd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  csd_digit_t load_digit,
  input  logic       load_last,
  input  logic       take,
  output logic       valid,
  output csd_digit_t digit,
  output logic       last,
  output logic       free
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      digit <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      digit <= load_digit;
      last  <= load_last;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  assign free = !valid || take;

endmodule

// File: rtl/csd_nz_counter.sv
module csd_nz_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (bump)  count <= count + 1'b1;
  end

endmodule

// File: rtl/serial_csd_recoder.sv
module serial_csd_recoder
  import csd_pkg::*;
#(
  parameter int MAX_BITS = 16,
  localparam int CNT_W   = $clog2(MAX_BITS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_nz,
  output logic             out_neg,
  output logic             out_last,
  output logic [CNT_W-1:0] nz_count
);

  logic       start_acc;
  logic       slot_free;
  logic       emit;
  logic       emit_last;
  logic       ctrl_active;
  csd_digit_t emit_digit;
  csd_digit_t slot_digit;

  assign busy      = ctrl_active || out_valid;
  assign start_acc = start && !busy;

  csd_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_acc  (start_acc),
    .in_valid   (in_valid),
    .in_bit     (in_bit),
    .in_last    (in_last),
    .slot_free  (slot_free),
    .in_ready   (in_ready),
    .emit       (emit),
    .emit_digit (emit_digit),
    .emit_last  (emit_last),
    .active     (ctrl_active)
  );

  csd_out_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (emit),
    .load_digit (emit_digit),
    .load_last  (emit_last),
    .take       (out_ready),
    .valid      (out_valid),
    .digit      (slot_digit),
    .last       (out_last),
    .free       (slot_free)
  );

  csd_nz_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_acc),
    .bump  (emit && emit_digit.nz),
    .count (nz_count)
  );

  assign out_nz  = slot_digit.nz;
  assign out_neg = slot_digit.neg;

endmodule

// File: rtl/csd_recoder_checker.sv
module csd_recoder_checker #(
  parameter int MAX_BITS = 16,
  localparam int CNT_W   = $clog2(MAX_BITS + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_nz,
  input logic             out_neg,
  input logic             out_last,
  input logic [CNT_W-1:0] nz_count
);

  logic             prev_nz;
  logic [CNT_W+1:0] dig_seen;
  logic             take;

  assign take = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nz  <= 1'b0;
      dig_seen <= '0;
    end else if (start && !busy) begin
      prev_nz  <= 1'b0;
      dig_seen <= '0;
    end else if (take) begin
      prev_nz  <= out_last ? 1'b0 : out_nz;
      dig_seen <= out_last ? '0 : dig_seen + 1'b1;
    end
  end

  AST_DIGIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_neg |-> out_nz); // R1

  AST_NO_ADJ_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    take && prev_nz |-> !out_nz); // R2

  AST_LAST_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> !out_neg); // R4

  AST_NZ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    take && out_last |-> ({2'b00, nz_count} << 1) <= dig_seen + 2); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_nz) && $stable(out_neg) && $stable(out_last)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready && !out_valid); // R7

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && (nz_count == '0)); // R9

endmodule

bind serial_csd_recoder csd_recoder_checker #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_nz    (out_nz),
  .out_neg   (out_neg),
  .out_last  (out_last),
  .nz_count  (nz_count)
);

// File: tb/serial_csd_recoder_bench.sv
`timescale 1ns/1ps
module serial_csd_recoder_bench;

  localparam int MAX_BITS = 16;
  localparam int CNT_W    = $clog2(MAX_BITS + 2);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             busy;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_bit = 1'b0;
  logic             in_last = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic             out_nz;
  logic             out_neg;
  logic             out_last;
  logic [CNT_W-1:0] nz_count;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  serial_csd_recoder #(.MAX_BITS(MAX_BITS)) u_serial_csd_recoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_nz    (out_nz),
    .out_neg   (out_neg),
    .out_last  (out_last),
    .nz_count  (nz_count)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // closed-form non-adjacent form reference: +1 where (3x^x)&3x, -1 where (3x^x)&x, shifted down one
  function automatic int ref_digit(input int x, input int i);
    int x3, np;
    x3 = 3 * x;
    np = x3 ^ x;
    if (((np & x3) >> (i + 1)) & 1) return 1;
    if (((np & x) >> (i + 1)) & 1) return -1;
    return 0;
  endfunction

  function automatic int ref_weight(input int x);
    int np, c;
    np = ((3 * x) ^ x) >> 1;
    c = 0;
    for (int b = 0; b < 32; b++) c += (np >> b) & 1;
    return c;
  endfunction

  // one word: start, stream bits with gaps, drain digits with a stall pattern
  task automatic run_word(input int x, input int nbits, input int gap, input int stall,
                          input bit poke, input string tag);
    int got[0:39];
    int cnt, code_err, hold_err, adj_err, last_err, mism, rebuilt;
    bit done;
    cnt = 0; code_err = 0; hold_err = 0; adj_err = 0; last_err = 0; mism = 0; rebuilt = 0;
    done = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    fork
      begin : drive
        for (int i = 0; i < nbits; i++) begin
          @(negedge clk);
          in_valid = 1'b0; start = 1'b0;
          repeat (gap) @(negedge clk);
          in_valid = 1'b1;
          in_bit   = ((x >> i) & 1) != 0;
          in_last  = (i == nbits - 1);
          if (poke && i == 2) start = 1'b1;
          #1;
          while (!in_ready) begin @(negedge clk); #1; end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
      end
      begin : drain
        int k;
        bit pend;
        logic [2:0] held;
        k = 0; pend = 1'b0; held = '0;
        while (!done) begin
          @(negedge clk);
          case (stall)
            0: out_ready = 1'b1;
            1: out_ready = k[0];
            default: out_ready = ((k % 5) == 4);
          endcase
          k++;
          #1;
          if (pend && !(out_valid && {out_nz, out_neg, out_last} == held)) hold_err++;
          pend = out_valid && !out_ready;
          held = {out_nz, out_neg, out_last};
          if (out_valid && out_ready) begin
            if (!out_nz && out_neg) code_err++;
            if (cnt < 40) got[cnt] = out_nz ? (out_neg ? -1 : 1) : 0;
            if (cnt > 0 && cnt < 40 && got[cnt] != 0 && got[cnt-1] != 0) adj_err++;
            if (out_last && cnt != nbits) last_err++;
            if (out_last && out_neg) last_err++;
            cnt++;
            if (out_last) done = 1'b1;
          end
        end
        @(negedge clk);
        out_ready = 1'b1;
      end
    join
    for (int i = 0; i < cnt && i < 40; i++) begin
      rebuilt += got[i] * (1 << i);
      if (got[i] != ref_digit(x, i)) mism++;
    end
    check(cnt == nbits + 1, "R4", {tag, " digit count"}, cnt, nbits + 1);
    check(last_err == 0, "R4", {tag, " last flag placement"}, last_err, 0);
    check(code_err == 0 && rebuilt == x, "R1", {tag, " rebuilt value"}, rebuilt, x);
    check(mism == 0, tag == "r3_23" ? "R3" : "R1", {tag, " digit mismatches vs reference"}, mism, 0);
    check(adj_err == 0, "R2", {tag, " adjacent nonzero pairs"}, adj_err, 0);
    check(hold_err == 0, "R6", {tag, " stall hold errors"}, hold_err, 0);
    check(busy == 1'b0, "R9", {tag, " busy after last digit"}, busy, 0);
    check(int'(nz_count) == ref_weight(x), "R5", {tag, " nz_count"}, nz_count, ref_weight(x));
    check(2 * int'(nz_count) <= nbits + 2, "R5", {tag, " nz_count bound"}, nz_count, (nbits + 2) / 2);
  endtask

  task automatic t_reset;
    check(busy == 1'b0 && in_ready == 1'b0 && out_valid == 1'b0, "R8", "reset handshake outputs",
          {busy, in_ready, out_valid}, 0);
    check(nz_count == '0, "R8", "reset nz_count", nz_count, 0);
  endtask

  task automatic t_idle_bits_ignored;
    int seen;
    seen = 0;
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    repeat (6) begin
      @(negedge clk); #1;
      if (in_ready || out_valid || busy) seen++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    check(seen == 0, "R7", "idle input bits produced activity", seen, 0);
    check(nz_count == '0, "R7", "idle input bits left nz_count", nz_count, 0);
  endtask

  task automatic t_random(input int words);
    int unsigned seed;
    int n, x;
    seed = 32'h1234_5678;
    for (int w = 0; w < words; w++) begin
      seed = seed * 1103515245 + 12345;
      n = 1 + int'((seed >> 16) % MAX_BITS);
      x = int'((seed >> 4) & ((32'h1 << n) - 1));
      run_word(x, n, w % 3, w % 3, 1'b0, "r1_rand");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();                                     // R8
    t_idle_bits_ignored();                         // R7
    run_word(23, 6, 0, 0, 1'b0, "r3_23");          // R3
    run_word(255, 8, 0, 0, 1'b0, "r4_ones");       // R4 carry into closing digit
    run_word(0, 4, 1, 0, 1'b0, "r1_zero");
    run_word(170, 8, 0, 1, 1'b0, "r2_alt");
    run_word(1, 1, 0, 0, 1'b0, "r4_one_bit");
    run_word(0, 1, 0, 2, 1'b0, "r4_zero_bit");
    run_word(16'hB6DB, 16, 2, 2, 1'b0, "r6_stall");
    run_word(16'hFFFF, 16, 0, 1, 1'b0, "r5_max");
    run_word(45, 7, 0, 1, 1'b1, "r7_start_poke"); // R7 start while busy
    t_random(20);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule